// File: doc/BRIEF.md
# Adaptive Dual-Rate Clock Generator

This block derives every clock of an event-driven sampling converter from a single fast input clock. A divide-by-13 stage produces the normal-rate level, and a power-of-two stage after it produces a quarter-rate level. Three clocks leave the block. The detector clock runs at normal or quarter rate. The comparator clock is an inverted and delayed copy of the detector clock. The sampling clock follows the normal-rate level and can be gated off. Every output is driven straight from a flip-flop in the fast-clock domain.

Two request inputs come from external decision logic. The rate request chooses the detector rate. The sample-enable request opens or closes the sampling-clock gate. Both requests pass through synchronisers first. The rate select then changes only at an instant where both candidate levels are about to rise together, so the detector clock changes rate without a runt pulse and without losing phase. The sampling gate changes only while the normal-rate level is low, so every sampling pulse keeps its full width.

Top module: `evt_dual_rate_clkgen`

## Requirements
- R1: With `rate_full_req`=1 (normal rate), `det_clk` is high for 6 and low for 7 fast cycles, a period of 13.
- R2: With both requests at 1, `samp_clk` is equal to `det_clk` in every fast cycle.
- R3: With `rate_full_req`=0 (quarter rate), once it has taken effect `det_clk` is high for 26 and low for 26 fast cycles.
- R4: At all times, including across rate changes, every high run of `det_clk` lasts 6 or 26 fast cycles and every low run lasts 7 or 26. Every high run of `samp_clk` lasts exactly 6 fast cycles, and every low run of `samp_clk` lasts 7+13k cycles.
- R5: Within 20 fast cycles after `samp_en_req` goes to 0, `samp_clk` stays low. Within 33 fast cycles after it returns to 1, a pulse appears again.
- R6: `cmp_clk` equals the inverse of `det_clk` as it was CMP_DLY fast cycles earlier (default 1).
- R7: While `rst_n` is 0, `det_clk`=0, `samp_clk`=0 and `cmp_clk`=1. After reset the block runs at normal rate with sampling enabled.
- R8: The sampling clock keeps its 13-cycle period (6 high) while the detector clock runs at quarter rate.
- R9: After a change of `rate_full_req`, the first high pulse with the new length begins within 60 fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast input clock, 13 times the normal rate |
| rst_n | input | 1 | Active-low reset, synchronous to clk_fast |
| rate_full_req | input | 1 | 1 selects normal rate for the detector clock, 0 selects quarter rate |
| samp_en_req | input | 1 | 1 lets the sampling clock run, 0 holds it low |
| det_clk | output | 1 | Detector clock, normal or quarter rate |
| cmp_clk | output | 1 | Inverted detector clock, delayed by CMP_DLY fast cycles |
| samp_clk | output | 1 | Gated normal-rate sampling clock |

## Verification
After a request changes, the result has a latency: two synchroniser cycles, then a wait for the switching window, then one output register. For a rate change that is at most 60 fast cycles, and for the gate it is at most 20. The bench therefore counts cycles from each change and tests the bound, and it judges the new rate only on a complete high run that starts after the bound. The run-length rules of R4 and the delay rule of R6 are checked in every cycle, including cycles where the requests toggle at random. All samples are taken on the falling edge, half a cycle after the registers update.

// File: rtl/evt_clk_pkg.sv
`timescale 1ns/1ps
package evt_clk_pkg;

  // level of a divided clock for a given count: high for the first floor(div/2) counts
  function automatic logic phase_hi(input int unsigned cnt, input int unsigned div);
    return cnt < (div / 2);
  endfunction

  // modulo increment used by every divider stage
  function automatic int unsigned wrap_inc(input int unsigned cnt, input int unsigned lim);
    return (cnt >= lim - 1) ? 0 : cnt + 1;
  endfunction

endpackage

// File: rtl/evt_odd_div.sv
`timescale 1ns/1ps
module evt_odd_div #(
  parameter int unsigned DIV = 13
) (
  input  logic clk,
  input  logic rst_n,
  output logic lvl,
  output logic wrap_pre
);
  import evt_clk_pkg::*;

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          lvl_q;

  always_comb begin
    cnt_d = CW'(wrap_inc(int'(cnt_q), DIV));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= phase_hi(0, DIV);
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= phase_hi(int'(cnt_d), DIV);
    end
  end

  assign lvl      = lvl_q;
  assign wrap_pre = (cnt_q == LAST);
endmodule

// File: rtl/evt_pow2_div.sv
`timescale 1ns/1ps
module evt_pow2_div #(
  parameter int unsigned RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic lvl,
  output logic mid_pre
);
  localparam int unsigned QW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [QW-1:0] MID = QW'(RATIO / 2 - 1);

  logic [QW-1:0] q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (adv) begin
      q_q <= q_q + QW'(1);
    end
  end

  assign lvl     = q_q[QW-1];
  assign mid_pre = (q_q == MID);
endmodule

// File: rtl/evt_bit_sync.sv
`timescale 1ns/1ps
module evt_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[gi] <= RST_VAL;
          else        chain_q[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[gi] <= RST_VAL;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/evt_dual_rate_clkgen.sv
`timescale 1ns/1ps
module evt_dual_rate_clkgen #(
  parameter int unsigned DIV_NORM    = 13,
  parameter int unsigned QUART_RATIO = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CMP_DLY     = 1
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic rate_full_req,
  input  logic samp_en_req,
  output logic det_clk,
  output logic cmp_clk,
  output logic samp_clk
);
  // named internal events, observed by the bound checker
  logic norm_lvl;
  logic norm_wrap_pre;
  logic quart_lvl;
  logic quart_mid_pre;
  logic rate_sync;
  logic gate_sync;
  logic swap_win;
  logic rate_sel_q;
  logic gate_q;
  logic det_q;
  logic samp_q;
  logic [CMP_DLY-1:0] dly_q;

  evt_odd_div #(.DIV(DIV_NORM)) u_norm (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .lvl      (norm_lvl),
    .wrap_pre (norm_wrap_pre)
  );

  evt_pow2_div #(.RATIO(QUART_RATIO)) u_quart (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .adv     (norm_wrap_pre),
    .lvl     (quart_lvl),
    .mid_pre (quart_mid_pre)
  );

  evt_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rate_sync (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .din   (rate_full_req),
    .dout  (rate_sync)
  );

  evt_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_gate_sync (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .din   (samp_en_req),
    .dout  (gate_sync)
  );

  // both candidate levels are low now and both rise at the next edge
  assign swap_win = norm_wrap_pre & quart_mid_pre;

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      rate_sel_q <= 1'b1;
      gate_q     <= 1'b1;
      det_q      <= 1'b0;
      samp_q     <= 1'b0;
    end else begin
      if (swap_win) rate_sel_q <= rate_sync;
      if (!norm_lvl) gate_q    <= gate_sync;
      det_q  <= rate_sel_q ? norm_lvl : quart_lvl;
      samp_q <= gate_q & norm_lvl;
    end
  end

  // comparator clock: fixed delay line of fast-clock stages, then inversion
  generate
    genvar di;
    for (di = 0; di < CMP_DLY; di++) begin : g_dly
      if (di == 0) begin : g_head
        always_ff @(posedge clk_fast) begin
          if (!rst_n) dly_q[di] <= 1'b0;
          else        dly_q[di] <= det_q;
        end
      end else begin : g_tail
        always_ff @(posedge clk_fast) begin
          if (!rst_n) dly_q[di] <= 1'b0;
          else        dly_q[di] <= dly_q[di-1];
        end
      end
    end
  endgenerate

  assign det_clk  = det_q;
  assign samp_clk = samp_q;
  assign cmp_clk  = ~dly_q[CMP_DLY-1];
endmodule

// File: rtl/evt_clkgen_checks.sv
`timescale 1ns/1ps
module evt_clkgen_checks #(
  parameter int unsigned CMP_DLY = 1
) (
  input logic clk_fast,
  input logic rst_n,
  input logic det_clk,
  input logic cmp_clk,
  input logic samp_clk,
  input logic norm_lvl,
  input logic quart_lvl,
  input logic swap_win,
  input logic rate_sel_q,
  input logic gate_q
);
  AST_SEL_AT_WINDOW: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(rate_sel_q) |-> $past(swap_win)); // R4

  AST_GATE_WHILE_LOW: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(gate_q) |-> !$past(norm_lvl)); // R5

  AST_SAMP_NEEDS_NORM: assert property (@(posedge clk_fast) disable iff (!rst_n)
    samp_clk |-> $past(norm_lvl)); // R2

  AST_QUART_ON_NORM_RISE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(quart_lvl) |-> $rose(norm_lvl)); // R3

  AST_DET_FROM_SOURCE: assert property (@(posedge clk_fast) disable iff (!rst_n)
    det_clk |-> ($past(norm_lvl) || $past(quart_lvl))); // R1

  generate
    if (CMP_DLY == 1) begin : g_cmp1
      AST_CMP_INV_DELAY: assert property (@(posedge clk_fast) disable iff (!rst_n)
        cmp_clk != $past(det_clk)); // R6
    end
  endgenerate
endmodule

bind evt_dual_rate_clkgen evt_clkgen_checks #(.CMP_DLY(CMP_DLY)) u_chk (
  .clk_fast   (clk_fast),
  .rst_n      (rst_n),
  .det_clk    (det_clk),
  .cmp_clk    (cmp_clk),
  .samp_clk   (samp_clk),
  .norm_lvl   (norm_lvl),
  .quart_lvl  (quart_lvl),
  .swap_win   (swap_win),
  .rate_sel_q (rate_sel_q),
  .gate_q     (gate_q)
);

// File: tb/sim_evt_dual_rate_clkgen.sv
`timescale 1ns/1ps
module sim_evt_dual_rate_clkgen;
  localparam int DIVN = 13;
  localparam int QR   = 4;
  localparam int DLY  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_full_req = 1'b1;
  logic samp_en_req = 1'b1;
  logic det_clk, cmp_clk, samp_clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_dual_rate_clkgen #(.DIV_NORM(DIVN), .QUART_RATIO(QR), .SYNC_STAGES(2), .CMP_DLY(DLY)) u0 (
    .clk_fast(clk), .rst_n(rst_n), .rate_full_req(rate_full_req), .samp_en_req(samp_en_req),
    .det_clk(det_clk), .cmp_clk(cmp_clk), .samp_clk(samp_clk)
  );

  // expected run lengths, restated from the requirements
  function automatic int hi_norm();  return DIVN / 2; endfunction
  function automatic int lo_norm();  return DIVN - DIVN / 2; endfunction
  function automatic int hi_quart(); return DIVN * QR / 2; endfunction
  function automatic int lo_quart(); return DIVN * QR - DIVN * QR / 2; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles until det_clk is next seen rising, and the length of that high run
  task automatic next_high(output int len, output int lead);
    lead = 0;
    while (det_clk == 1'b1) begin @(negedge clk); lead++; end
    while (det_clk == 1'b0) begin @(negedge clk); lead++; end
    len = 0;
    while (det_clk == 1'b1) begin @(negedge clk); len++; end
  endtask

  task automatic next_low(output int len);
    while (det_clk == 1'b0) @(negedge clk);
    while (det_clk == 1'b1) @(negedge clk);
    len = 0;
    while (det_clk == 1'b0) begin @(negedge clk); len++; end
  endtask

  // R9: cycles from a rate change to the start of the first high run of length want
  task automatic rate_latency(input int want, output int lat);
    int elapsed = 0;
    int len, lead;
    lat = -1;
    for (int k = 0; k < 6 && lat < 0; k++) begin
      next_high(len, lead);
      if (len == want) lat = elapsed + lead;
      elapsed += lead + len;
    end
  endtask

  // continuous run-length and delay monitor (R4, R6)
  bit mon_on = 0;
  int det_run, samp_run, warm;
  bit det_prev, samp_prev, det_first, samp_first;
  bit det_hist [0:7];

  always @(negedge clk) begin
    if (!mon_on) begin
      det_run = 0; samp_run = 0; warm = 0;
      det_first = 1; samp_first = 1;
      det_prev = det_clk; samp_prev = samp_clk;
      for (int i = 0; i < 8; i++) det_hist[i] = 1'b0;
    end else begin
      for (int i = 7; i > 0; i--) det_hist[i] = det_hist[i-1];
      det_hist[0] = det_clk;
      if (warm < 8) warm++;
      else check(cmp_clk == ~det_hist[DLY], "R6 cmp_clk", cmp_clk, ~det_hist[DLY]);

      if (det_clk == det_prev) det_run++;
      else begin
        if (!det_first) begin
          if (det_prev)
            check(det_run == hi_norm() || det_run == hi_quart(), "R4 det high run", det_run, hi_norm());
          else
            check(det_run == lo_norm() || det_run == lo_quart(), "R4 det low run", det_run, lo_norm());
        end
        det_first = 0; det_run = 1; det_prev = det_clk;
      end

      if (samp_clk == samp_prev) samp_run++;
      else begin
        if (!samp_first) begin
          if (samp_prev)
            check(samp_run == hi_norm(), "R4 samp high run", samp_run, hi_norm());
          else
            check(samp_run >= lo_norm() && (samp_run - lo_norm()) % DIVN == 0,
                  "R4 samp low run", samp_run, lo_norm());
        end
        samp_first = 0; samp_run = 1; samp_prev = samp_clk;
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, lead, lat, mism, seen;
    void'($urandom(32'd20240601));

    // R7: reset values
    cyc(5);
    check(det_clk == 1'b0, "R7 det_clk in reset", det_clk, 0);
    check(samp_clk == 1'b0, "R7 samp_clk in reset", samp_clk, 0);
    check(cmp_clk == 1'b1, "R7 cmp_clk in reset", cmp_clk, 1);
    rst_n = 1'b1;
    mon_on = 1;
    cyc(3);

    // R1: normal rate run lengths
    next_high(len, lead);
    check(len == hi_norm(), "R1 det high", len, hi_norm());
    next_low(len);
    check(len == lo_norm(), "R1 det low", len, lo_norm());

    // R2: sampling equals detector at full rate
    mism = 0;
    for (int i = 0; i < 60; i++) begin
      if (samp_clk != det_clk) mism++;
      cyc(1);
    end
    check(mism == 0, "R2 samp equals det", mism, 0);

    // R3, R9: go to quarter rate
    rate_full_req = 1'b0;
    rate_latency(hi_quart(), lat);
    check(lat >= 0 && lat <= 60, "R9 latency to quarter", lat, 60);
    next_high(len, lead);
    check(len == hi_quart(), "R3 det high quarter", len, hi_quart());
    next_low(len);
    check(len == lo_quart(), "R3 det low quarter", len, lo_quart());

    // R8: sampling keeps normal rate while detector is slow
    seen = 0;
    for (int i = 0; i < 52; i++) begin
      if (samp_clk && !samp_prev) seen++;
      cyc(1);
    end
    check(seen == 4, "R8 samp pulses in 52 cycles", seen, 4);

    // R5: gate off then on
    samp_en_req = 1'b0;
    cyc(20);
    mism = 0;
    for (int i = 0; i < 60; i++) begin
      if (samp_clk) mism++;
      cyc(1);
    end
    check(mism == 0, "R5 samp held low", mism, 0);
    samp_en_req = 1'b1;
    cyc(20);
    seen = 0;
    for (int i = 0; i < 14; i++) begin
      if (samp_clk) seen = 1;
      cyc(1);
    end
    check(seen == 1, "R5 samp resumes", seen, 1);

    // R9, R1: back to normal rate
    rate_full_req = 1'b1;
    rate_latency(hi_norm(), lat);
    check(lat >= 0 && lat <= 60, "R9 latency to normal", lat, 60);
    next_high(len, lead);
    check(len == hi_norm(), "R1 det high after return", len, hi_norm());

    // random toggling of both requests; R4 and R6 monitored throughout
    for (int s = 0; s < 120; s++) begin
      if ($urandom_range(0, 2) == 0) rate_full_req = ~rate_full_req;
      if ($urandom_range(0, 1) == 0) samp_en_req = $urandom_range(0, 1);
      cyc($urandom_range(3, 120));
    end

    // settle both to on and confirm R2 again
    rate_full_req = 1'b1;
    samp_en_req = 1'b1;
    cyc(100);
    mism = 0;
    for (int i = 0; i < 40; i++) begin
      if (samp_clk != det_clk) mism++;
      cyc(1);
    end
    check(mism == 0, "R2 samp equals det after random", mism, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule